// File: doc/BRIEF.md
# Two-Processor Doorbell Signaling Controller

This block lets two processors tell each other that a message is waiting, and tell the sender when the message has been consumed. The message itself lives in shared memory outside the block. There are `NUM_CH` channels, six by default. Each channel has two independent one-way lanes, one forward (processor 1 to processor 2) and one reverse (processor 2 to processor 1). Each lane holds a single busy/free bit.

Each processor has its own small register port and its own two interrupt lines. The receive line fires while an unmasked lane aimed at that processor is busy. The transmit line fires while an unmasked lane owned by that processor is free.

Flag ownership is split. Only the sending side can mark its lane busy, and only the receiving side can mark it free. Both actions are single write-one-to-act accesses, so no read-modify-write is ever needed. The two ports are fully independent and may be written in the same cycle.

Top module: `dual_core_doorbell`

## Requirements
- R1: After reset all lane flags are free, every mask bit is 1 (masked), both interrupt enables are 0 and all four interrupt outputs are low.
- R2: A write to offset 2 of a port sets that port's outgoing lane flags wherever wdata bits [21:16] are 1 (bit 16+i is channel i). The flag reads back as 1 at offset 3 of the owner and at offset 4 of the peer on the cycle after the write edge.
- R3: A write to offset 2 clears the writing port's incoming lane flags wherever wdata bits [5:0] are 1. A port cannot clear its own outgoing lanes, and it cannot set the peer's outgoing lanes.
- R4: Zero bits in an offset 2 write leave the matching flags unchanged.
- R5: The receive interrupt of a port is a register. It is high one cycle after a state in which control bit 0 is 1 and some incoming flag i is 1 while receive mask bit i (offset 1 bit i) is 0.
- R6: The transmit interrupt of a port is a register. It is high one cycle after a state in which control bit 1 is 1 and some outgoing flag i is 0 while transmit mask bit i (offset 1 bit 16+i) is 0.
- R7: If a sender sets a lane and the receiver clears the same lane in the same cycle, the lane ends up busy.
- R8: The read data is combinational from the current address. Offset 0 gives {txEnable, rxEnable} in bits [1:0], offset 1 gives the receive masks in [5:0] and the transmit masks in [21:16], offset 3 gives the outgoing flags, offset 4 gives the incoming flags, and every other offset and bit reads 0.
- R9: Both ports may write in the same cycle, and each write takes full effect with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p1We | input | 1 | Processor 1 write enable |
| p1Addr | input | 3 | Processor 1 register offset |
| p1Wdata | input | 32 | Processor 1 write data |
| p1Rdata | output | 32 | Processor 1 read data |
| p1RxIrq | output | 1 | Processor 1 receive-busy interrupt |
| p1TxIrq | output | 1 | Processor 1 transmit-free interrupt |
| p2We | input | 1 | Processor 2 write enable |
| p2Addr | input | 3 | Processor 2 register offset |
| p2Wdata | input | 32 | Processor 2 write data |
| p2Rdata | output | 32 | Processor 2 read data |
| p2RxIrq | output | 1 | Processor 2 receive-busy interrupt |
| p2TxIrq | output | 1 | Processor 2 transmit-free interrupt |

## Verification
The assertions assume that writes and addresses are stable across each rising edge. They also assume that a lane can change state only through an offset 2 write on one of the two ports, so they relate every rise or fall of a flag to such a write in the previous cycle.

The stimulus drives both ports only on the falling edge. It draws addresses from 0 to 5, so unused offsets get exercised as well. It ANDs two random words to form flag-action data, which keeps lanes switching between busy and free rather than saturating. Directed cycles cover the simultaneous set-and-clear case and the wrong-side case.

// File: rtl/doorbell_pkg.sv
`timescale 1ns/1ps
package doorbell_pkg;

  // register offsets; software depends on these positions
  localparam int OFS_CTL    = 0;
  localparam int OFS_MASK   = 1;
  localparam int OFS_ACT    = 2;
  localparam int OFS_OUTSTS = 3;
  localparam int OFS_INSTS  = 4;

  // control register bit positions
  localparam int CTL_RX_EN = 0;
  localparam int CTL_TX_EN = 1;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CTL  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_OUT  = 3'd3,
    SEL_IN   = 3'd4
  } rdSel_t;

  // strobes from the decode control to one register bank
  typedef struct packed {
    logic   ctlWr;
    logic   maskWr;
    logic   actWr;
    rdSel_t rdSel;
  } regStrobe_t;

endpackage

// File: rtl/doorbell_ctrl.sv
`timescale 1ns/1ps
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(OFS_ACT);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUTSTS);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_INSTS);

  always_comb begin
    strb        = '0;
    strb.rdSel  = SEL_NONE;
    if (addr == A_CTL) begin
      strb.ctlWr = we;
      strb.rdSel = SEL_CTL;
    end else if (addr == A_MASK) begin
      strb.maskWr = we;
      strb.rdSel  = SEL_MASK;
    end else if (addr == A_ACT) begin
      // action register is write-only, reads return zero
      strb.actWr = we;
    end else if (addr == A_OUT) begin
      strb.rdSel = SEL_OUT;
    end else if (addr == A_IN) begin
      strb.rdSel = SEL_IN;
    end
  end

endmodule

// File: rtl/doorbell_bank.sv
`timescale 1ns/1ps
module doorbell_bank
  import doorbell_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32,
  parameter int TX_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] outFlags,
  input  logic [NUM_CH-1:0] inFlags,
  output logic [NUM_CH-1:0] setReq,
  output logic [NUM_CH-1:0] clrReq,
  output logic [DATA_W-1:0] rdata,
  output logic              rxIrq,
  output logic              txIrq
);

  localparam int RX_LSB = 0;

  logic              rxEn;
  logic              txEn;
  logic [NUM_CH-1:0] rxMask;
  logic [NUM_CH-1:0] txMask;
  logic [NUM_CH-1:0] rxLive;
  logic [NUM_CH-1:0] txLive;

  // write-one-to-act requests toward the shared flag store
  assign setReq = strb.actWr ? wdata[TX_LSB +: NUM_CH] : '0;
  assign clrReq = strb.actWr ? wdata[RX_LSB +: NUM_CH] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxEn   <= 1'b0;
      txEn   <= 1'b0;
      rxMask <= '1;
      txMask <= '1;
    end else begin
      if (strb.ctlWr) begin
        rxEn <= wdata[CTL_RX_EN];
        txEn <= wdata[CTL_TX_EN];
      end
      if (strb.maskWr) begin
        rxMask <= wdata[RX_LSB +: NUM_CH];
        txMask <= wdata[TX_LSB +: NUM_CH];
      end
    end
  end

  // per-channel interrupt contributions
  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_live
      assign rxLive[ch] = inFlags[ch] & ~rxMask[ch];
      assign txLive[ch] = ~outFlags[ch] & ~txMask[ch];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxIrq <= 1'b0;
      txIrq <= 1'b0;
    end else begin
      rxIrq <= rxEn & (|rxLive);
      txIrq <= txEn & (|txLive);
    end
  end

  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      SEL_CTL: begin
        rdata[CTL_RX_EN] = rxEn;
        rdata[CTL_TX_EN] = txEn;
      end
      SEL_MASK: begin
        rdata[RX_LSB +: NUM_CH] = rxMask;
        rdata[TX_LSB +: NUM_CH] = txMask;
      end
      SEL_OUT:  rdata[NUM_CH-1:0] = outFlags;
      SEL_IN:   rdata[NUM_CH-1:0] = inFlags;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/doorbell_datapath.sv
`timescale 1ns/1ps
module doorbell_datapath
  import doorbell_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32,
  parameter int TX_LSB = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  regStrobe_t [1:0]            strb,
  input  logic [1:0][DATA_W-1:0]      wdata,
  output logic [1:0][DATA_W-1:0]      rdata,
  output logic [1:0]                  rxIrq,
  output logic [1:0]                  txIrq,
  output logic [1:0][NUM_CH-1:0]      outFlags
);

  localparam int SIDES = 2;

  logic [SIDES-1:0][NUM_CH-1:0] setReq;
  logic [SIDES-1:0][NUM_CH-1:0] clrReq;

  // outFlags[s] is owned (set) by side s and cleared by the other side;
  // a set in the same cycle as a clear leaves the lane busy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outFlags <= '0;
    end else begin
      for (int s = 0; s < SIDES; s++) begin
        outFlags[s] <= (outFlags[s] & ~clrReq[SIDES-1-s]) | setReq[s];
      end
    end
  end

  genvar sd;
  generate
    for (sd = 0; sd < SIDES; sd++) begin : g_side
      doorbell_bank #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .TX_LSB (TX_LSB)
      ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb     (strb[sd]),
        .wdata    (wdata[sd]),
        .outFlags (outFlags[sd]),
        .inFlags  (outFlags[SIDES-1-sd]),
        .setReq   (setReq[sd]),
        .clrReq   (clrReq[sd]),
        .rdata    (rdata[sd]),
        .rxIrq    (rxIrq[sd]),
        .txIrq    (txIrq[sd])
      );
    end
  endgenerate

endmodule

// File: rtl/dual_core_doorbell.sv
`timescale 1ns/1ps
module dual_core_doorbell
  import doorbell_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int TX_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p1We,
  input  logic [ADDR_W-1:0] p1Addr,
  input  logic [DATA_W-1:0] p1Wdata,
  output logic [DATA_W-1:0] p1Rdata,
  output logic              p1RxIrq,
  output logic              p1TxIrq,
  input  logic              p2We,
  input  logic [ADDR_W-1:0] p2Addr,
  input  logic [DATA_W-1:0] p2Wdata,
  output logic [DATA_W-1:0] p2Rdata,
  output logic              p2RxIrq,
  output logic              p2TxIrq
);

  logic [1:0]              weV;
  logic [1:0][ADDR_W-1:0]  addrV;
  logic [1:0][DATA_W-1:0]  wdataV;
  logic [1:0][DATA_W-1:0]  rdataV;
  logic [1:0]              rxIrqV;
  logic [1:0]              txIrqV;
  logic [1:0][NUM_CH-1:0]  flagsV;
  regStrobe_t [1:0]        strbV;
  logic [NUM_CH-1:0]       fwdFlags;
  logic [NUM_CH-1:0]       revFlags;

  assign weV    = {p2We, p1We};
  assign addrV  = {p2Addr, p1Addr};
  assign wdataV = {p2Wdata, p1Wdata};

  genvar sd;
  generate
    for (sd = 0; sd < 2; sd++) begin : g_dec
      doorbell_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .we   (weV[sd]),
        .addr (addrV[sd]),
        .strb (strbV[sd])
      );
    end
  endgenerate

  doorbell_datapath #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .TX_LSB (TX_LSB)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strbV),
    .wdata    (wdataV),
    .rdata    (rdataV),
    .rxIrq    (rxIrqV),
    .txIrq    (txIrqV),
    .outFlags (flagsV)
  );

  assign fwdFlags = flagsV[0];
  assign revFlags = flagsV[1];
  assign p1Rdata  = rdataV[0];
  assign p2Rdata  = rdataV[1];
  assign p1RxIrq  = rxIrqV[0];
  assign p2RxIrq  = rxIrqV[1];
  assign p1TxIrq  = txIrqV[0];
  assign p2TxIrq  = txIrqV[1];

endmodule

// File: rtl/doorbell_checker.sv
`timescale 1ns/1ps
module doorbell_checker #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int TX_LSB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              p1We,
  input logic [ADDR_W-1:0] p1Addr,
  input logic [DATA_W-1:0] p1Wdata,
  input logic              p2We,
  input logic [ADDR_W-1:0] p2Addr,
  input logic [DATA_W-1:0] p2Wdata,
  input logic              p1RxIrq,
  input logic              p1TxIrq,
  input logic              p2RxIrq,
  input logic              p2TxIrq,
  input logic [NUM_CH-1:0] fwdFlags,
  input logic [NUM_CH-1:0] revFlags
);

  logic p1Act;
  logic p2Act;
  assign p1Act = p1We && (p1Addr == ADDR_W'(2));
  assign p2Act = p2We && (p2Addr == ADDR_W'(2));

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ch
      // R2: a forward lane becomes busy only after a set from processor 1
      a_r2_fwd_set_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwdFlags[i]) |-> $past(p1Act && p1Wdata[TX_LSB+i]));
      a_r2_rev_set_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(revFlags[i]) |-> $past(p2Act && p2Wdata[TX_LSB+i]));
      // R3: a lane becomes free only after a clear from its receiver
      a_r3_fwd_clr_by_peer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fwdFlags[i]) |-> $past(p2Act && p2Wdata[i]));
      a_r3_rev_clr_by_peer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(revFlags[i]) |-> $past(p1Act && p1Wdata[i]));
      // R7: a set is never lost, even against a clear in the same cycle
      a_r7_fwd_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (p1Act && p1Wdata[TX_LSB+i]) |=> fwdFlags[i]);
      a_r7_rev_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (p2Act && p2Wdata[TX_LSB+i]) |=> revFlags[i]);
    end
  endgenerate

  // R5: a receive interrupt needs a busy incoming lane one cycle earlier
  a_r5_p2_rx_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    p2RxIrq |-> $past(|fwdFlags));
  a_r5_p1_rx_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    p1RxIrq |-> $past(|revFlags));
  // R6: a transmit interrupt needs a free outgoing lane one cycle earlier
  a_r6_p1_tx_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    p1TxIrq |-> $past(~&fwdFlags));
  a_r6_p2_tx_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    p2TxIrq |-> $past(~&revFlags));

endmodule

bind dual_core_doorbell doorbell_checker #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .TX_LSB (TX_LSB)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .p1We     (p1We),
  .p1Addr   (p1Addr),
  .p1Wdata  (p1Wdata),
  .p2We     (p2We),
  .p2Addr   (p2Addr),
  .p2Wdata  (p2Wdata),
  .p1RxIrq  (p1RxIrq),
  .p1TxIrq  (p1TxIrq),
  .p2RxIrq  (p2RxIrq),
  .p2TxIrq  (p2TxIrq),
  .fwdFlags (fwdFlags),
  .revFlags (revFlags)
);

// File: tb/dual_core_doorbell_test.sv
`timescale 1ns/1ps
module dual_core_doorbell_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p1We = 1'b0, p2We = 1'b0;
  logic [2:0]  p1Addr = '0, p2Addr = '0;
  logic [31:0] p1Wdata = '0, p2Wdata = '0;
  logic [31:0] p1Rdata, p2Rdata;
  logic        p1RxIrq, p1TxIrq, p2RxIrq, p2TxIrq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_core_doorbell uut (
    .clk(clk), .rst_n(rst_n),
    .p1We(p1We), .p1Addr(p1Addr), .p1Wdata(p1Wdata), .p1Rdata(p1Rdata),
    .p1RxIrq(p1RxIrq), .p1TxIrq(p1TxIrq),
    .p2We(p2We), .p2Addr(p2Addr), .p2Wdata(p2Wdata), .p2Rdata(p2Rdata),
    .p2RxIrq(p2RxIrq), .p2TxIrq(p2TxIrq)
  );

  // reference state: index 0 is processor 1, index 1 is processor 2
  logic [5:0] mOut [2];
  logic [1:0] mCtl [2];
  logic [5:0] mRx  [2];
  logic [5:0] mTx  [2];

  function automatic logic expRx(int s);
    return mCtl[s][0] & (|(mOut[1-s] & ~mRx[s]));
  endfunction

  function automatic logic expTx(int s);
    return mCtl[s][1] & (|(~mOut[s] & ~mTx[s]));
  endfunction

  function automatic logic [31:0] expRead(int s, logic [2:0] a);
    case (a)
      3'd0: return {30'd0, mCtl[s]};
      3'd1: return {10'd0, mTx[s], 10'd0, mRx[s]};
      3'd3: return {26'd0, mOut[s]};
      3'd4: return {26'd0, mOut[1-s]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic modelStep(logic [1:0] we, logic [2:0] a [2], logic [31:0] d [2]);
    logic [5:0] st [2];
    logic [5:0] cl [2];
    for (int s = 0; s < 2; s++) begin
      st[s] = (we[s] && a[s] == 3'd2) ? d[s][21:16] : 6'd0;
      cl[s] = (we[s] && a[s] == 3'd2) ? d[s][5:0] : 6'd0;
    end
    for (int s = 0; s < 2; s++) begin
      mOut[s] = (mOut[s] & ~cl[1-s]) | st[s];
      if (we[s] && a[s] == 3'd0) mCtl[s] = d[s][1:0];
      if (we[s] && a[s] == 3'd1) begin
        mRx[s] = d[s][5:0];
        mTx[s] = d[s][21:16];
      end
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, check at the next falling edge
  task automatic cycle(string tag, logic w1, logic [2:0] a1, logic [31:0] d1,
                       logic w2, logic [2:0] a2, logic [31:0] d2);
    logic [2:0]  aa [2];
    logic [31:0] dd [2];
    logic [1:0]  ex, et;
    aa[0] = a1; aa[1] = a2; dd[0] = d1; dd[1] = d2;
    p1We = w1; p1Addr = a1; p1Wdata = d1;
    p2We = w2; p2Addr = a2; p2Wdata = d2;
    for (int s = 0; s < 2; s++) begin
      ex[s] = expRx(s);
      et[s] = expTx(s);
    end
    modelStep({w2, w1}, aa, dd);
    @(negedge clk);
    check({tag, "/R5 p1 rx irq"}, {31'd0, p1RxIrq}, {31'd0, ex[0]});
    check({tag, "/R5 p2 rx irq"}, {31'd0, p2RxIrq}, {31'd0, ex[1]});
    check({tag, "/R6 p1 tx irq"}, {31'd0, p1TxIrq}, {31'd0, et[0]});
    check({tag, "/R6 p2 tx irq"}, {31'd0, p2TxIrq}, {31'd0, et[1]});
    check({tag, "/R8 p1 read"}, p1Rdata, expRead(0, a1));
    check({tag, "/R8 p2 read"}, p2Rdata, expRead(1, a2));
  endtask

  task automatic idle(string tag, logic [2:0] a1, logic [2:0] a2);
    cycle(tag, 1'b0, a1, 32'd0, 1'b0, a2, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      mOut[s] = '0; mCtl[s] = '0; mRx[s] = '1; mTx[s] = '1;
    end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values through every offset of both ports
    for (int a = 0; a < 8; a++) idle("R1", 3'(a), 3'(a));

    // R2: processor 1 sets channels 0 and 2; peer sees them as incoming
    cycle("R2", 1'b1, 3'd2, 32'h0005_0000, 1'b0, 3'd4, 32'd0);
    idle("R2", 3'd3, 3'd4);
    check("R2 p2 incoming", p2Rdata, 32'h5);

    // R3: processor 2 set field touches only its own lane; p1 clear field hits only incoming
    cycle("R3", 1'b0, 3'd3, 32'd0, 1'b1, 3'd2, 32'h0002_0000);
    cycle("R3", 1'b1, 3'd2, 32'h0000_003F, 1'b0, 3'd3, 32'd0);
    idle("R3", 3'd3, 3'd3);
    check("R3 fwd kept", p1Rdata, 32'h5);
    check("R3 rev cleared", p2Rdata, 32'h0);

    // R4: zero data in the action register changes nothing
    cycle("R4", 1'b1, 3'd2, 32'd0, 1'b1, 3'd2, 32'd0);
    idle("R4", 3'd3, 3'd4);
    check("R4 unchanged", p1Rdata, 32'h5);

    // R7: set and clear of channel 0 in the same cycle
    cycle("R7", 1'b1, 3'd2, 32'h0001_0000, 1'b1, 3'd2, 32'h0000_0001);
    idle("R7", 3'd3, 3'd4);
    check("R7 set wins", p2Rdata, 32'h5);

    // R5: processor 2 unmasks receive channel 0 and enables its receive interrupt
    cycle("R5", 1'b0, 3'd0, 32'd0, 1'b1, 3'd1, 32'h003F_003E);
    cycle("R5", 1'b0, 3'd0, 32'd0, 1'b1, 3'd0, 32'h1);
    idle("R5", 3'd0, 3'd0);
    check("R5 p2 rx high", {31'd0, p2RxIrq}, 32'd1);
    cycle("R5", 1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'h1);
    idle("R5", 3'd0, 3'd0);
    check("R5 p2 rx low", {31'd0, p2RxIrq}, 32'd0);

    // R6: processor 1 unmasks transmit channel 3 (free) and enables transmit interrupt
    cycle("R6", 1'b1, 3'd1, 32'h0037_003F, 1'b0, 3'd0, 32'd0);
    cycle("R6", 1'b1, 3'd0, 32'h2, 1'b0, 3'd0, 32'd0);
    idle("R6", 3'd1, 3'd0);
    check("R6 p1 tx high", {31'd0, p1TxIrq}, 32'd1);
    cycle("R6", 1'b1, 3'd2, 32'h0008_0000, 1'b0, 3'd0, 32'd0);
    idle("R6", 3'd0, 3'd0);
    check("R6 p1 tx low", {31'd0, p1TxIrq}, 32'd0);

    // R9: both ports write different registers in the same cycle
    cycle("R9", 1'b1, 3'd0, 32'h3, 1'b1, 3'd2, 32'h003F_000F);
    idle("R9", 3'd0, 3'd3);
    check("R9 p1 ctl", p1Rdata, 32'h3);
    check("R9 p2 out", p2Rdata, 32'h3F);

    // random traffic on both ports, checked against the reference model
    for (int n = 0; n < 4000; n++) begin
      logic [2:0]  ra1, ra2;
      logic [31:0] rd1, rd2;
      ra1 = 3'($urandom % 6);
      ra2 = 3'($urandom % 6);
      rd1 = (ra1 == 3'd0) ? 32'($urandom % 4) : ($urandom & $urandom);
      rd2 = (ra2 == 3'd0) ? 32'($urandom % 4) : ($urandom & $urandom);
      cycle("R9 rand", 1'($urandom % 2), ra1, rd1, 1'($urandom % 2), ra2, rd2);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule